// File: doc/BRIEF.md
# I2C Master Clock and Bus-Condition Timer

This block produces the SCL waveform and the timing of start, repeated-start and stop conditions for one I2C master. All time is counted in ticks from an external clock pre-divider, never in raw system clocks. A single 3-bit low-time code sets the minimum SCL low time. The same count also sets the repeated-start setup time, the start hold, the stop setup and the bus-free time after a stop. A second 3-bit code sets the SCL high time. Both codes mean code + 2 ticks.

A byte sequencer above this block issues one command at a time: start, transfer one bit, or repeated start. It sees `done_o` when each bit, start or stop is finished. The block drives open-drain enables for SCL and SDA. It reads the real SCL line back through a synchronizer, so a slave or another master can stretch the clock. A stop request is a separate single-cycle pulse. It is held until the bus reaches a point where a stop is allowed. If the master is receiving at that point, one NACK bit is sent before the stop.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset, `scl_oe_o` and `sda_oe_o` are 0 (both lines released), `cmd_ready_o` is 1 and `done_o` is 0.
- R2: The low phase of a bit, with `scl_oe_o`=1, lasts exactly `low_code_i`+2 pre-divider ticks. Codes 0 to 7 give 2 to 9 ticks.
- R3: The high phase of a bit counts `high_code_i`+2 ticks. Ticks are counted only while SCL, after a 2-cycle synchronizer, reads high. A device that holds SCL low lengthens the phase without shortening the counted high time.
- R4: During both phases of a bit, `sda_oe_o` equals the inverse of the `tx_bit_i` value that was captured when the command was accepted, and it does not change.
- R5: Command codes on `cmd_i` are 0 = start, 1 = bit, 2 = repeated start; 3 is ignored. A start from idle pulls SDA low with SCL released for L = `low_code_i`+2 ticks, then pulls SCL low and pulses `done_o`.
- R6: A repeated start does three things in order. It releases SDA with SCL low for L ticks. It then releases SCL and waits L ticks of SCL seen high. Finally it performs a start as in R5.
- R7: A stop runs through four phases in order. It pulls SDA low with SCL low for L ticks. It releases SCL and waits L ticks of SCL seen high. It releases SDA and waits L more ticks (bus-free time). It then pulses `done_o` and returns to idle.
- R8: A `stop_req_i` pulse that arrives during a bit is held until that bit completes, and the stop then follows without a command. While the stop is pending, `cmd_ready_o` is 0.
- R9: When `rx_mode_i` is 1 at the point where a pending stop would begin, one bit with SDA released (NACK) is sent first. The stop follows it.
- R10: A `stop_req_i` pulse while the bus is idle has no effect: the lines stay released, `cmd_ready_o` stays 1 and no `done_o` appears.
- R11: `done_o` lasts one cycle per finished bit, start or stop. Commands are taken only when `cmd_ready_o` is 1. A bit or repeated start issued while idle, or a start issued while holding the bus, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle tick from the clock pre-divider |
| low_code_i | input | 3 | Low-time code, interval = code + 2 ticks |
| high_code_i | input | 3 | High-time code, interval = code + 2 ticks |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 2 | 0 start, 1 bit, 2 repeated start, 3 ignored |
| tx_bit_i | input | 1 | Bit value to place on SDA (1 = release) |
| rx_mode_i | input | 1 | Master is receiving; a stop then inserts a NACK |
| stop_req_i | input | 1 | One-cycle stop request pulse |
| scl_i | input | 1 | Actual SCL line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| cmd_ready_o | output | 1 | A command can be taken this cycle |
| done_o | output | 1 | One-cycle pulse when a bit, start or stop ends |

## Verification
The hardest case to reach is a stop requested in the middle of a bit while the master is receiving. To expose it, the request must arrive inside the low phase. The bit must then be seen to finish untouched, an extra released-SDA bit must follow, and the stop must come last, all without any further command. The bench pulses the stop request a few cycles into the low phase of a bit. It then follows the next three operations by counting pre-divider ticks in each combination of line states. Clock stretching is produced by a wired-AND model of SCL. That model holds the line low for a set number of cycles after the block releases it, which shows that the high count only starts once the line is high.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_START = 4'd1,
    ST_HOLD  = 4'd2,
    ST_BLO   = 4'd3,
    ST_BHI   = 4'd4,
    ST_RSA   = 4'd5,
    ST_RSB   = 4'd6,
    ST_SPA   = 4'd7,
    ST_SPB   = 4'd8,
    ST_BUF   = 4'd9
  } scl_state_e;

  localparam logic [1:0] CMD_START  = 2'd0;
  localparam logic [1:0] CMD_BIT    = 2'd1;
  localparam logic [1:0] CMD_RSTART = 2'd2;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q[0] <= 1'b1;
          else        q[0] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q[i] <= 1'b1;
          else        q[i] <= q[i-1];
        end
      end
    end
  endgenerate

  assign line_o = q[STAGES-1];
endmodule

// File: rtl/i2c_tick_counter.sv
module i2c_tick_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expire_o = tick_i && !clear_i && (cnt_q == target_i - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)       cnt_d = '0;
    else if (expire_o) cnt_d = '0;
    else if (tick_i)   cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_scl_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] low_code_i,
  input  logic [CODE_W-1:0] high_code_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic              tx_bit_i,
  input  logic              rx_mode_i,
  input  logic              stop_req_i,
  input  logic              scl_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              cmd_ready_o,
  output logic              done_o
);
  localparam int CNT_W = CODE_W + 1;

  scl_state_e state_q, state_d;
  logic bit_q, bit_d;
  logic pend_q, pend_d;
  logic nacked_q, nacked_d;
  logic done_q, done_d;
  logic scl_s, pend_eff, gated, cnt_en, cnt_clr, expire;
  logic [CNT_W-1:0] target;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_s)
  );

  assign gated   = (state_q == ST_BHI) || (state_q == ST_RSB) || (state_q == ST_SPB);
  assign cnt_en  = tick_i && (!gated || scl_s);
  assign cnt_clr = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign target  = (state_q == ST_BHI) ? ({1'b0, high_code_i} + CNT_W'(2))
                                       : ({1'b0, low_code_i}  + CNT_W'(2));

  i2c_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear_i(cnt_clr), .tick_i(cnt_en),
    .target_i(target), .expire_o(expire)
  );

  assign pend_eff = pend_q || stop_req_i;

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid_i && cmd_i == CMD_START) begin
                  state_d = ST_START;
                  bit_d   = 1'b0;
                end
      ST_START: if (expire) begin state_d = ST_HOLD; done_d = 1'b1; end
      ST_HOLD: begin
        if (pend_eff) begin
          if (rx_mode_i && !nacked_q) begin
            state_d = ST_BLO;
            bit_d   = 1'b1;
          end else begin
            state_d = ST_SPA;
          end
        end else if (cmd_valid_i && cmd_i == CMD_BIT) begin
          state_d = ST_BLO;
          bit_d   = tx_bit_i;
        end else if (cmd_valid_i && cmd_i == CMD_RSTART) begin
          state_d = ST_RSA;
        end
      end
      ST_BLO:   if (expire) state_d = ST_BHI;
      ST_BHI:   if (expire) begin state_d = ST_HOLD; done_d = 1'b1; end
      ST_RSA:   if (expire) state_d = ST_RSB;
      ST_RSB:   if (expire) begin state_d = ST_START; bit_d = 1'b0; end
      ST_SPA:   if (expire) state_d = ST_SPB;
      ST_SPB:   if (expire) state_d = ST_BUF;
      ST_BUF:   if (expire) begin state_d = ST_IDLE; done_d = 1'b1; end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (state_q == ST_IDLE || (state_q == ST_HOLD && state_d == ST_SPA))
      pend_d = 1'b0;
    else if (stop_req_i && (state_q == ST_START || state_q == ST_HOLD ||
                            state_q == ST_BLO   || state_q == ST_BHI  ||
                            state_q == ST_RSA   || state_q == ST_RSB))
      pend_d = 1'b1;
  end

  always_comb begin
    nacked_d = nacked_q;
    if (state_q == ST_IDLE || state_d == ST_SPA)
      nacked_d = 1'b0;
    else if (state_q == ST_HOLD && state_d == ST_BLO && pend_eff)
      nacked_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bit_q    <= 1'b1;
      pend_q   <= 1'b0;
      nacked_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      bit_q    <= bit_d;
      pend_q   <= pend_d;
      nacked_q <= nacked_d;
      done_q   <= done_d;
    end
  end

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    unique case (state_q)
      ST_START: sda_oe_o = 1'b1;
      ST_HOLD:  begin scl_oe_o = 1'b1; sda_oe_o = !bit_q; end
      ST_BLO:   begin scl_oe_o = 1'b1; sda_oe_o = !bit_q; end
      ST_BHI:   sda_oe_o = !bit_q;
      ST_RSA:   scl_oe_o = 1'b1;
      ST_SPA:   begin scl_oe_o = 1'b1; sda_oe_o = 1'b1; end
      ST_SPB:   sda_oe_o = 1'b1;
      default:  ;
    endcase
  end

  assign cmd_ready_o = (state_q == ST_IDLE) || (state_q == ST_HOLD && !pend_q);
  assign done_o      = done_q;
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk
  import i2c_scl_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input scl_state_e state_q,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       done,
  input logic       cmd_ready
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_READY_ONLY_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (state_q == ST_IDLE || state_q == ST_HOLD)); // R11

  AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BHI && !scl_s) |=> (state_q == ST_BHI)); // R3

  AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BHI && $past(state_q) == ST_BHI) |-> $stable(sda_oe)); // R4

  AST_STOP_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SPA && $past(state_q) != ST_SPA) |-> ($past(state_q) == ST_HOLD)); // R8
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state_q(state_q), .scl_s(scl_s),
  .sda_oe(sda_oe_o), .done(done_o), .cmd_ready(cmd_ready_o)
);

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;
  localparam logic [1:0] C_START = 2'd0, C_BIT = 2'd1, C_RS = 2'd2;
  localparam int NVEC = 4;
  localparam logic [6:0] VEC [NVEC] = '{
    {3'd0, 3'd0, 1'b0}, {3'd7, 3'd3, 1'b1}, {3'd3, 3'd7, 1'b0}, {3'd5, 3'd1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic [2:0] low_code, high_code;
  logic cmd_valid, tx_bit, rx_mode, stop_req;
  logic [1:0] cmd;
  logic scl_line, scl_oe, sda_oe, cmd_ready, done;

  int checks = 0, fails = 0, cyc = 0;
  int n_ls, n_lr, n_hs, n_hr, n_hicyc;
  int divc, hi_cyc, stretch_req;
  logic [1:0] sh;

  always #10 clk = ~clk;

  i2c_scl_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .low_code_i(low_code),
    .high_code_i(high_code), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .tx_bit_i(tx_bit), .rx_mode_i(rx_mode), .stop_req_i(stop_req),
    .scl_i(scl_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .cmd_ready_o(cmd_ready), .done_o(done)
  );

  assign tick     = (divc == 2);
  assign scl_line = !scl_oe && (hi_cyc >= stretch_req);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divc <= 0; hi_cyc <= 0; sh <= 2'b11;
    end else begin
      divc   <= (divc == 2) ? 0 : divc + 1;
      hi_cyc <= scl_oe ? 0 : ((hi_cyc < 100000) ? hi_cyc + 1 : hi_cyc);
      sh     <= {sh[0], scl_line};
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic run_op(input int kind, input logic [1:0] c, input logic b, input int stop_at);
    logic got_done = 1'b0;
    n_ls = 0; n_lr = 0; n_hs = 0; n_hr = 0; n_hicyc = 0;
    if (kind == 1) begin cmd = c; tx_bit = b; cmd_valid = 1'b1; end
    else if (kind == 2) stop_req = 1'b1;
    for (int k = 1; k < 4000; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      stop_req  = (k == stop_at);
      if (done) begin got_done = 1'b1; break; end
      if (scl_oe  &&  sda_oe && tick) n_ls++;
      if (scl_oe  && !sda_oe && tick) n_lr++;
      if (!scl_oe &&  sda_oe && sh[1] && tick) n_hs++;
      if (!scl_oe && !sda_oe && sh[1] && tick) n_hr++;
      if (!scl_oe) n_hicyc++;
    end
    stop_req = 1'b0;
    chk("R11 done seen", int'(got_done), 1);
  endtask

  task automatic idle_cycles(input int n, input int exp_scl, input string req);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0; stop_req = 1'b0;
      if (int'(scl_oe) != exp_scl || done) bad++;
    end
    chk(req, bad, 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int L, H;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd = 2'd0; tx_bit = 1'b1; rx_mode = 1'b0;
    stop_req = 1'b0; low_code = 3'd0; high_code = 3'd0; stretch_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    chk("R1 ready", int'(cmd_ready), 1);
    chk("R1 done", int'(done), 0);

    // Vector table: start, bit, stop per entry
    for (int v = 0; v < NVEC; v++) begin
      low_code = VEC[v][6:4]; high_code = VEC[v][3:1];
      L = int'(low_code) + 2; H = int'(high_code) + 2;
      run_op(1, C_START, 1'b1, 0);
      chk("R5 start sda-low scl-high ticks", n_hs, L);
      chk("R5 start no scl-low ticks", n_ls + n_lr, 0);
      run_op(1, C_BIT, VEC[v][0], 0);
      chk("R2 low ticks", VEC[v][0] ? n_lr : n_ls, L);
      chk("R3 high ticks", VEC[v][0] ? n_hr : n_hs, H);
      chk("R4 sda other value ticks", VEC[v][0] ? (n_ls + n_hs) : (n_lr + n_hr), 0);
      @(negedge clk);
      chk("R11 done one cycle", int'(done), 0);
      run_op(2, C_BIT, 1'b1, 0);
      chk("R7 stop setup low ticks", n_ls, L);
      chk("R7 stop scl-high sda-low ticks", n_hs, L);
      chk("R7 bus free ticks", n_hr, L);
      chk("R7 idle after stop", int'(cmd_ready && !scl_oe && !sda_oe), 1);
    end

    // R10 stop request while idle; R11 bit command while idle
    low_code = 3'd1; high_code = 3'd2; L = 3; H = 4;
    stop_req = 1'b1;
    idle_cycles(20, 0, "R10 stop in idle no effect");
    chk("R10 ready stays", int'(cmd_ready && !sda_oe), 1);
    cmd = C_BIT; cmd_valid = 1'b1;
    idle_cycles(20, 0, "R11 bit in idle ignored");

    // R3 stretching; R11 start while holding ignored; R6 repeated start
    run_op(1, C_START, 1'b1, 0);
    stretch_req = 25;
    run_op(1, C_BIT, 1'b0, 0);
    stretch_req = 0;
    chk("R3 stretched high ticks", n_hs, H);
    chk("R3 stretched phase longer", int'(n_hicyc > 25), 1);
    cmd = C_START; cmd_valid = 1'b1;
    idle_cycles(15, 1, "R11 start in hold ignored");
    run_op(1, C_RS, 1'b1, 0);
    chk("R6 sda release with scl low", n_lr, L);
    chk("R6 setup with scl high", n_hr, L);
    chk("R6 start after setup", n_hs, L);
    chk("R6 no other ticks", n_ls, 0);

    // R8 stop during a bit, transmitting
    run_op(1, C_BIT, 1'b1, 3);
    chk("R8 bit completes low", n_lr, L);
    chk("R8 bit completes high", n_hr, H);
    chk("R8 ready low while pending", int'(cmd_ready), 0);
    run_op(0, C_BIT, 1'b1, 0);
    chk("R8 stop follows", n_ls, L);
    chk("R8 stop bus free", n_hr, L);

    // R9 stop while receiving: NACK then stop
    rx_mode = 1'b1;
    run_op(1, C_START, 1'b1, 0);
    run_op(1, C_BIT, 1'b0, 3);
    chk("R9 current bit low", n_ls, L);
    chk("R9 current bit high", n_hs, H);
    run_op(0, C_BIT, 1'b1, 0);
    chk("R9 nack low released", n_lr, L);
    chk("R9 nack high released", n_hr, H);
    chk("R9 nack no sda pull", n_ls + n_hs, 0);
    run_op(0, C_BIT, 1'b1, 0);
    chk("R9 stop after nack", n_ls, L);
    chk("R9 stop setup high", n_hs, L);
    chk("R9 bus free", n_hr, L);
    rx_mode = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule